// File: doc/BRIEF.md
# Autoincrement and Autodecrement Register Update Unit

This unit serves the operand-specifier stage of a 16-bit two-operand processor. For each specifier it receives the 3-bit addressing mode, the 3-bit register number, the current register contents, a byte/word flag and a source/destination flag. One clock later it returns four things: the effective operand address, the new register value, the register number, and a one-cycle write-enable pulse. The pulse is raised only when the register has to be written back.

The register-stepping modes are mode 2 (post-increment), mode 3 (post-increment, deferred), mode 4 (pre-decrement) and mode 5 (pre-decrement, deferred). The step is 2 by default. It is 1 only for a byte operation in mode 2 or mode 4 on one of the general registers r0 to r5. The stack pointer (r6) and the program counter (r7) keep word alignment. The deferred modes always step by 2, because the register holds the address of a word pointer.

The deferred memory fetch, the data path and instruction decode lie outside this unit. The surrounding pipeline writes the returned value into its register file before it presents the next specifier. A destination specifier that names the same register as the source therefore starts from the value the source already updated.

Top module: `autoinc_update`

## Requirements
- R1: In mode 2 (code 3'b010) the address is the old register value and the new value is the old value plus the step. The step is 1 for a byte operation (in_byte=1) on r0..r5 and 2 otherwise.
- R2: In mode 4 (code 3'b100) the new value is the old value minus the step, and the address equals the new value. The step follows the same byte/word and register rule as R1.
- R3: Mode 3 (3'b011) and mode 5 (3'b101) always step by 2, even when in_byte=1. Mode 3 uses the old value as the address. Mode 5 uses the decremented value as the address.
- R4: For register 6 (stack pointer), modes 2 and 4 step by 2 even for byte operations.
- R5: For register 7 (program counter), modes 2 and 3 step by 2 even for byte operations.
- R6: The source/destination flag has no effect on the step, the address or the new value. It is returned unchanged on out_is_dst.
- R7: Modes 0, 1, 6 and 7 raise no write enable. For these modes out_addr and out_value both equal the input register value.
- R8: All arithmetic wraps modulo 2^16: 16'hFFFF+1 gives 16'h0000, 16'hFFFF+2 gives 16'h0001, and 16'h0000-2 gives 16'hFFFE.
- R9: A request accepted on a clock edge with in_valid=1 produces out_valid=1 for exactly one cycle after that edge. out_wr_en is high only together with out_valid and only in modes 2 to 5. out_reg returns the request's register number.
- R10: While rst is high on a clock edge, out_valid and out_wr_en are 0 after that edge, whatever in_valid is.
- R11: When the returned value is written back before the next specifier, a destination specifier on the same register sees the value already updated by the source specifier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe |
| in_mode | input | 3 | Addressing mode code |
| in_reg | input | 3 | Register number |
| in_value | input | 16 | Current register contents |
| in_byte | input | 1 | 1 for a byte operation |
| in_is_dst | input | 1 | 1 for a destination specifier |
| out_valid | output | 1 | Result strobe, one cycle after in_valid |
| out_wr_en | output | 1 | Register write-back pulse |
| out_reg | output | 3 | Register to write back |
| out_value | output | 16 | Updated register value |
| out_addr | output | 16 | Effective operand address |
| out_is_dst | output | 1 | Source/destination flag, returned unchanged |

## Verification
The bench targets three kinds of mistake.

The first is the step size. A design that keys the step on the byte flag alone steps the stack pointer, the program counter or a deferred pointer by 1, leaving it odd.

The second is the address in the decrement modes. A design that takes the address from the old value instead of the decremented one gives an address that is one step too high.

The third is the write enable. A design that raises it in modes 0, 1, 6 or 7 corrupts a register. A design that does not wrap at 16 bits gives wrong values at 16'hFFFF and 16'h0000.

The bench also chains a source and a destination specifier on the same register through a register-file model. A design that hands back the wrong register number or a stale value leaves the destination pointing at the old address.

// File: rtl/addr_step_pkg.sv
package addr_step_pkg;

    localparam int WORD_W = 16;
    localparam int RSEL_W = 3;
    localparam int NUM_REGS = 1 << RSEL_W;

    typedef enum logic [2:0] {
        AM_REG      = 3'd0,
        AM_REG_DEF  = 3'd1,
        AM_POSTINC  = 3'd2,
        AM_POSTINC_D= 3'd3,
        AM_PREDEC   = 3'd4,
        AM_PREDEC_D = 3'd5,
        AM_INDEX    = 3'd6,
        AM_INDEX_D  = 3'd7
    } amode_e;

    typedef struct packed {
        amode_e              mode;
        logic [RSEL_W-1:0]   rsel;
        logic [WORD_W-1:0]   value;
        logic                byte_op;
        logic                is_dst;
    } spec_req_t;

    typedef struct packed {
        logic [WORD_W-1:0]   addr;
        logic [WORD_W-1:0]   value;
        logic [RSEL_W-1:0]   rsel;
        logic                wr;
        logic                is_dst;
    } spec_res_t;

    function automatic logic is_post(input amode_e m);
        return (m == AM_POSTINC) || (m == AM_POSTINC_D);
    endfunction

    function automatic logic is_pre(input amode_e m);
        return (m == AM_PREDEC) || (m == AM_PREDEC_D);
    endfunction

    function automatic logic is_deferred_step(input amode_e m);
        return (m == AM_POSTINC_D) || (m == AM_PREDEC_D);
    endfunction

endpackage

// File: rtl/autoinc_step_sel.sv
module autoinc_step_sel
    import addr_step_pkg::*;
#(
    parameter int SP_IDX = 6
) (
    input  amode_e              mode,
    input  logic [RSEL_W-1:0]   rsel,
    input  logic                byte_op,
    output logic [WORD_W-1:0]   step
);
    // Registers that must stay word aligned.
    logic [NUM_REGS-1:0] word_only;

    genvar gi;
    generate
        for (gi = 0; gi < NUM_REGS; gi++) begin : g_align
            assign word_only[gi] = (gi >= SP_IDX);
        end
    endgenerate

    logic unit_step;
    always_comb begin
        unit_step = byte_op && !is_deferred_step(mode) && !word_only[rsel];
        step      = unit_step ? WORD_W'(1) : WORD_W'(2);
    end

endmodule

// File: rtl/autoinc_addr_calc.sv
module autoinc_addr_calc
    import addr_step_pkg::*;
(
    input  spec_req_t           req,
    input  logic [WORD_W-1:0]   step,
    output spec_res_t           res
);
    logic [WORD_W-1:0] incd;
    logic [WORD_W-1:0] decd;

    always_comb begin
        incd = req.value + step;
        decd = req.value - step;
        res.rsel   = req.rsel;
        res.is_dst = req.is_dst;
        if (is_post(req.mode)) begin
            res.addr  = req.value;
            res.value = incd;
            res.wr    = 1'b1;
        end else if (is_pre(req.mode)) begin
            res.addr  = decd;
            res.value = decd;
            res.wr    = 1'b1;
        end else begin
            res.addr  = req.value;
            res.value = req.value;
            res.wr    = 1'b0;
        end
    end

endmodule

// File: rtl/autoinc_update.sv
module autoinc_update
    import addr_step_pkg::*;
#(
    parameter int SP_IDX = 6
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 in_valid,
    input  logic [2:0]           in_mode,
    input  logic [RSEL_W-1:0]    in_reg,
    input  logic [WORD_W-1:0]    in_value,
    input  logic                 in_byte,
    input  logic                 in_is_dst,
    output logic                 out_valid,
    output logic                 out_wr_en,
    output logic [RSEL_W-1:0]    out_reg,
    output logic [WORD_W-1:0]    out_value,
    output logic [WORD_W-1:0]    out_addr,
    output logic                 out_is_dst
);
    spec_req_t         req;
    spec_res_t         res_c;
    spec_res_t         res_q;
    logic              vld_q;
    logic [WORD_W-1:0] step;

    always_comb begin
        req.mode    = amode_e'(in_mode);
        req.rsel    = in_reg;
        req.value   = in_value;
        req.byte_op = in_byte;
        req.is_dst  = in_is_dst;
    end

    autoinc_step_sel #(.SP_IDX(SP_IDX)) u_step (
        .mode    (req.mode),
        .rsel    (req.rsel),
        .byte_op (req.byte_op),
        .step    (step)
    );

    autoinc_addr_calc u_calc (
        .req  (req),
        .step (step),
        .res  (res_c)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q <= 1'b0;
            res_q <= '0;
        end else begin
            vld_q <= in_valid;
            if (in_valid) begin
                res_q <= res_c;
            end
        end
    end

    assign out_valid  = vld_q;
    assign out_wr_en  = vld_q && res_q.wr;
    assign out_reg    = res_q.rsel;
    assign out_value  = res_q.value;
    assign out_addr   = res_q.addr;
    assign out_is_dst = res_q.is_dst;

    a_r9_latency: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    a_r9_wr_qualified: assert property (@(posedge clk) disable iff (rst)
        out_wr_en |-> out_valid);

    a_r7_no_write: assert property (@(posedge clk) disable iff (rst)
        (in_valid && (in_mode <= 3'd1 || in_mode >= 3'd6))
        |=> (!out_wr_en && out_addr == $past(in_value) && out_value == $past(in_value)));

    a_r1_post_addr: assert property (@(posedge clk) disable iff (rst)
        (in_valid && (in_mode == 3'd2 || in_mode == 3'd3))
        |=> (out_wr_en && out_addr == $past(in_value)));

    a_r2_pre_addr: assert property (@(posedge clk) disable iff (rst)
        (in_valid && (in_mode == 3'd4 || in_mode == 3'd5))
        |=> (out_wr_en && out_addr == out_value));

    a_r3_deferred_step: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_mode == 3'd3)
        |=> (WORD_W'(out_value - out_addr) == WORD_W'(2)));

    a_r4_sp_step: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_mode == 3'd4 && in_reg == RSEL_W'(SP_IDX))
        |=> (WORD_W'($past(in_value) - out_value) == WORD_W'(2)));

endmodule

// File: tb/autoinc_update_test.sv
module autoinc_update_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [2:0]  in_mode = '0;
    logic [2:0]  in_reg = '0;
    logic [15:0] in_value = '0;
    logic        in_byte = 1'b0;
    logic        in_is_dst = 1'b0;
    logic        out_valid, out_wr_en, out_is_dst;
    logic [2:0]  out_reg;
    logic [15:0] out_value, out_addr;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #4 clk = ~clk;

    autoinc_update uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_mode(in_mode),
        .in_reg(in_reg), .in_value(in_value), .in_byte(in_byte),
        .in_is_dst(in_is_dst), .out_valid(out_valid), .out_wr_en(out_wr_en),
        .out_reg(out_reg), .out_value(out_value), .out_addr(out_addr),
        .out_is_dst(out_is_dst)
    );

    // {req, mode, reg, byte, dst, value, exp_addr, exp_value, exp_we}
    localparam int NV = 20;
    localparam logic [60:0] VEC [NV] = '{
        {4'd1, 3'd2,3'd0,1'b1,1'b0,16'h1000,16'h1000,16'h1001,1'b1}, // R1 byte
        {4'd1, 3'd2,3'd1,1'b0,1'b0,16'h1000,16'h1000,16'h1002,1'b1}, // R1 word
        {4'd2, 3'd4,3'd2,1'b1,1'b1,16'h1000,16'h0FFF,16'h0FFF,1'b1}, // R2 byte
        {4'd2, 3'd4,3'd3,1'b0,1'b0,16'h1000,16'h0FFE,16'h0FFE,1'b1}, // R2 word
        {4'd3, 3'd3,3'd4,1'b1,1'b0,16'h2000,16'h2000,16'h2002,1'b1}, // R3
        {4'd3, 3'd5,3'd5,1'b1,1'b1,16'h2000,16'h1FFE,16'h1FFE,1'b1}, // R3
        {4'd4, 3'd2,3'd6,1'b1,1'b0,16'h0400,16'h0400,16'h0402,1'b1}, // R4
        {4'd4, 3'd4,3'd6,1'b1,1'b1,16'h0400,16'h03FE,16'h03FE,1'b1}, // R4
        {4'd5, 3'd2,3'd7,1'b1,1'b0,16'h0100,16'h0100,16'h0102,1'b1}, // R5
        {4'd5, 3'd3,3'd7,1'b1,1'b1,16'h0100,16'h0100,16'h0102,1'b1}, // R5
        {4'd6, 3'd2,3'd0,1'b1,1'b1,16'h1000,16'h1000,16'h1001,1'b1}, // R6
        {4'd6, 3'd4,3'd5,1'b1,1'b0,16'h1000,16'h0FFF,16'h0FFF,1'b1}, // R6
        {4'd7, 3'd0,3'd1,1'b1,1'b0,16'h1234,16'h1234,16'h1234,1'b0}, // R7
        {4'd7, 3'd1,3'd2,1'b0,1'b1,16'h1234,16'h1234,16'h1234,1'b0}, // R7
        {4'd7, 3'd6,3'd3,1'b0,1'b0,16'h5555,16'h5555,16'h5555,1'b0}, // R7
        {4'd7, 3'd7,3'd4,1'b1,1'b1,16'h5555,16'h5555,16'h5555,1'b0}, // R7
        {4'd8, 3'd2,3'd1,1'b0,1'b0,16'hFFFF,16'hFFFF,16'h0001,1'b1}, // R8
        {4'd8, 3'd4,3'd0,1'b0,1'b1,16'h0000,16'hFFFE,16'hFFFE,1'b1}, // R8
        {4'd8, 3'd2,3'd2,1'b1,1'b0,16'hFFFF,16'hFFFF,16'h0000,1'b1}, // R8
        {4'd8, 3'd5,3'd3,1'b0,1'b0,16'h0001,16'hFFFF,16'hFFFF,1'b1}  // R8
    };

    task automatic check(input string req, input string what,
                         input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Drive one request; on return the result is visible (negedge after capture).
    task automatic issue(input logic [2:0] m, input logic [2:0] r, input logic [15:0] v,
                         input logic b, input logic d);
        @(negedge clk);
        in_valid = 1'b1; in_mode = m; in_reg = r; in_value = v;
        in_byte = b; in_is_dst = d;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    logic [15:0] rf [8];

    initial begin
        repeat (3) @(negedge clk);
        // R10: reset state
        check("R10", "out_valid", 16'(out_valid), 16'd0);
        check("R10", "out_wr_en", 16'(out_wr_en), 16'd0);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            logic [60:0] e;
            string rq;
            e = VEC[i];
            rq = $sformatf("R%0d", e[60:57]);
            issue(e[56:54], e[53:51], e[48:33], e[50], e[49]);
            check(rq, "addr", out_addr, e[32:17]);
            check(rq, "value", out_value, e[16:1]);
            check(rq, "wr_en", 16'(out_wr_en), 16'(e[0]));
            check("R9", "out_valid", 16'(out_valid), 16'd1);
            check("R9", "out_reg", 16'(out_reg), 16'(e[53:51]));
            check("R6", "out_is_dst", 16'(out_is_dst), 16'(e[49]));
        end

        // R9: pulse lasts one cycle
        @(negedge clk);
        check("R9", "valid drop", 16'(out_valid), 16'd0);
        check("R9", "wr drop", 16'(out_wr_en), 16'd0);

        // R6: same request as source and destination gives identical results
        issue(3'd4, 3'd3, 16'h0800, 1'b1, 1'b0);
        begin
            logic [15:0] a0, v0;
            a0 = out_addr; v0 = out_value;
            issue(3'd4, 3'd3, 16'h0800, 1'b1, 1'b1);
            check("R6", "dst addr", out_addr, a0);
            check("R6", "dst value", out_value, v0);
        end

        // R11: source (r0)+ then destination (r0) through a register-file model
        for (int k = 0; k < 8; k++) rf[k] = 16'h0;
        rf[0] = 16'h1000;
        issue(3'd2, 3'd0, rf[0], 1'b0, 1'b0);
        if (out_wr_en) rf[out_reg] = out_value;
        issue(3'd1, 3'd0, rf[0], 1'b0, 1'b1);
        check("R11", "dst addr after (r0)+", out_addr, 16'h1002);
        // R11: byte (r1)+ then -(r1) returns to the start address
        rf[1] = 16'h3000;
        issue(3'd2, 3'd1, rf[1], 1'b1, 1'b0);
        if (out_wr_en) rf[out_reg] = out_value;
        issue(3'd4, 3'd1, rf[1], 1'b1, 1'b1);
        if (out_wr_en) rf[out_reg] = out_value;
        check("R11", "r1 restored", rf[1], 16'h3000);
        check("R11", "dst addr", out_addr, 16'h3000);

        // R10: reset while a request is offered
        @(negedge clk);
        rst = 1'b1; in_valid = 1'b1; in_mode = 3'd2;
        @(negedge clk);
        check("R10", "valid in reset", 16'(out_valid), 16'd0);
        check("R10", "wr in reset", 16'(out_wr_en), 16'd0);
        in_valid = 1'b0; rst = 1'b0;
        @(negedge clk);

        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule